// File: doc/BRIEF.md
# Host-to-Core Byte Mailbox with Status Flags

This block passes single bytes in both directions between an external host processor and the processor inside the chip. The host writes a byte into an inbound data register and the core reads it. The core writes a byte into an outbound data register and the host reads it. A status byte tells each side when data is waiting: an inbound-full flag, an outbound-full flag, a flag that records whether the last host write was a command or data, and one general flag that the core can set.

The host side is asynchronous to the core clock. It has an active-low chip select, one address line, active-low write and read strobes, and a data bus. Each strobe is synchronised into the core clock, and an access takes effect on the strobe's completing (rising) edge. The host must hold chip select, the address line and write data stable from before the strobe falls until SYNC_STAGES+2 core clocks after it rises. The core side uses single-cycle-clean strobes in the core clock domain. The inbound-full flag is also the core's interrupt request.

Top module: `hs_mailbox`

## Requirements
- R1: After reset the status byte, the inbound register, the outbound register and the interrupt are all zero.
- R2: A host write (h_cs_n low, rising edge of h_wr_n) loads h_wdata into the inbound register and sets inbound-full (status bit 1). This happens at the SYNC_STAGES-th core clock edge that follows the first edge to sample h_wr_n high, whatever the address line is.
- R3: Every host write copies h_addr into the command/data flag (status bit 3): 1 for command, 0 for data.
- R4: Inbound-full clears on the first core clock edge that samples s_idr_rd low after it was high (the falling edge of the core read strobe). s_irq always equals inbound-full.
- R5: When s_odr_wr falls, outbound-full (status bit 0) sets. The outbound register holds the last s_wdata sampled while s_odr_wr was high.
- R6: A host read with h_addr low clears outbound-full on the rising edge of h_rd_n. A host read with h_addr high leaves outbound-full unchanged.
- R7: h_rdata shows the status byte when h_addr is 1 and the outbound register when h_addr is 0. Status bits 7 to 4 read as 0.
- R8: Host write and read strobes have no effect while h_cs_n is high.
- R9: A pulse on s_gf_wr loads s_wdata bit 2 into the general flag (status bit 2) and ignores all other s_wdata bits.
- R10: When a set event and a clear event for the same full flag fall on the same clock edge, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_addr | input | 1 | Host address line: 1 selects status or command, 0 selects data |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data |
| s_idr_rd | input | 1 | Core read strobe for the inbound register |
| s_odr_wr | input | 1 | Core write strobe for the outbound register |
| s_gf_wr | input | 1 | Core write strobe for the general flag |
| s_wdata | input | DATA_W | Core write data |
| s_idr | output | DATA_W | Inbound register contents |
| s_status | output | DATA_W | Status byte |
| s_irq | output | 1 | Interrupt request to the core, equal to inbound-full |

## Verification
The bench uses the default DATA_W=8 and SYNC_STAGES=2. This makes the host-write latency a fixed two edges after the first high sample, and the bench checks the flag just before and just after that edge. With the latency known, the bench can line up a core read-strobe fall with a host write on the same edge to test the set-over-clear priority. It does the same with a core write-strobe fall and a host data read.

// File: rtl/hs_mbox_pkg.sv
package hs_mbox_pkg;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int GF_BIT  = 2;
  localparam int CD_BIT  = 3;
  localparam int FLAG_W  = 4;
endpackage

// File: rtl/hs_sync_rise.sv
module hs_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  assign sh_d = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[LAST] & ~sh_q[STAGES];
endmodule

// File: rtl/hs_mbox_core.sv
module hs_mbox_core
  import hs_mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_clr,
  input  logic              h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              s_idr_rd,
  input  logic              s_odr_wr,
  input  logic              s_gf_wr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] idr,
  output logic [DATA_W-1:0] odr,
  output logic [DATA_W-1:0] status
);
  localparam int PAD_W = DATA_W - FLAG_W;

  logic rd_q, wr_q;
  logic ibf_q, obf_q, gf_q, cd_q;
  logic ibf_d, obf_d, gf_d, cd_d;
  logic [DATA_W-1:0] idr_q, odr_q, idr_d, odr_d;
  logic s_rd_fall, s_wr_fall;
  logic idr_en, odr_en, gf_en;

  assign s_rd_fall = rd_q & ~s_idr_rd;
  assign s_wr_fall = wr_q & ~s_odr_wr;

  always_comb begin
    idr_en = wr_evt;
    odr_en = s_odr_wr;
    gf_en  = s_gf_wr;
    idr_d  = h_wdata;
    odr_d  = s_wdata;
    gf_d   = s_wdata[GF_BIT];
    cd_d   = wr_evt ? h_addr : cd_q;
    // set takes priority over clear
    if (wr_evt)         ibf_d = 1'b1;
    else if (s_rd_fall) ibf_d = 1'b0;
    else                ibf_d = ibf_q;
    if (s_wr_fall)      obf_d = 1'b1;
    else if (rd_clr)    obf_d = 1'b0;
    else                obf_d = obf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
      cd_q  <= 1'b0;
      gf_q  <= 1'b0;
      idr_q <= '0;
      odr_q <= '0;
    end else begin
      rd_q  <= s_idr_rd;
      wr_q  <= s_odr_wr;
      ibf_q <= ibf_d;
      obf_q <= obf_d;
      cd_q  <= cd_d;
      if (gf_en)  gf_q  <= gf_d;
      if (idr_en) idr_q <= idr_d;
      if (odr_en) odr_q <= odr_d;
    end
  end

  assign idr    = idr_q;
  assign odr    = odr_q;
  assign status = {{PAD_W{1'b0}}, cd_q, gf_q, ibf_q, obf_q};
endmodule

// File: rtl/hs_mailbox.sv
module hs_mailbox
  import hs_mbox_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_cs_n,
  input  logic              h_addr,
  input  logic              h_wr_n,
  input  logic              h_rd_n,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              s_idr_rd,
  input  logic              s_odr_wr,
  input  logic              s_gf_wr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_idr,
  output logic [DATA_W-1:0] s_status,
  output logic              s_irq
);
  localparam int NSTB = 2;

  logic [1:0]      rst_q;
  logic            rst_ni;
  logic [NSTB-1:0] strobes_n;
  logic [NSTB-1:0] rises;
  logic            wr_evt, rd_clr;
  logic [DATA_W-1:0] odr, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  assign strobes_n = {h_rd_n, h_wr_n};

  for (genvar g = 0; g < NSTB; g++) begin : g_sync
    hs_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_ni),
      .async_in (strobes_n[g]),
      .rise     (rises[g])
    );
  end

  assign wr_evt = rises[0] & ~h_cs_n;
  assign rd_clr = rises[1] & ~h_cs_n & ~h_addr;

  hs_mbox_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_evt   (wr_evt),
    .rd_clr   (rd_clr),
    .h_addr   (h_addr),
    .h_wdata  (h_wdata),
    .s_idr_rd (s_idr_rd),
    .s_odr_wr (s_odr_wr),
    .s_gf_wr  (s_gf_wr),
    .s_wdata  (s_wdata),
    .idr      (s_idr),
    .odr      (odr),
    .status   (status)
  );

  assign h_rdata  = h_addr ? status : odr;
  assign s_status = status;
  assign s_irq    = status[IBF_BIT];
endmodule

// File: rtl/hs_mailbox_chk.sv
module hs_mailbox_chk
  import hs_mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              h_addr,
  input logic              wr_evt,
  input logic              rd_clr,
  input logic              s_idr_rd,
  input logic              s_odr_wr,
  input logic [DATA_W-1:0] status
);
  assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_evt |=> status[IBF_BIT]);

  assert_cd_latch_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_evt |=> (status[CD_BIT] == $past(h_addr)));

  assert_ibf_clr_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(s_idr_rd) && !wr_evt) |=> !status[IBF_BIT]);

  assert_obf_set_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(s_odr_wr) |=> status[OBF_BIT]);

  assert_obf_clr_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_clr && !$fell(s_odr_wr)) |=> !status[OBF_BIT]);

  assert_ibf_src_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(status[IBF_BIT]) |-> $past(wr_evt));
endmodule

bind hs_mailbox hs_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .h_addr   (h_addr),
  .wr_evt   (wr_evt),
  .rd_clr   (rd_clr),
  .s_idr_rd (s_idr_rd),
  .s_odr_wr (s_odr_wr),
  .status   (status)
);

// File: tb/tb_hs_mailbox.sv
module tb_hs_mailbox;
  localparam int DW  = 8;
  localparam int LAT = 2;
  localparam logic [2:0] OP_HWR = 3'd0, OP_HRD = 3'd1, OP_SRD = 3'd2,
                         OP_SWR = 3'd3, OP_SGF = 3'd4;
  // {op, addr, data, expected status, expected host read data}
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {OP_HWR, 1'b0, 8'h5A, 8'h02, 8'h00},
    {OP_SRD, 1'b0, 8'h00, 8'h00, 8'h00},
    {OP_HWR, 1'b1, 8'hC3, 8'h0A, 8'h00},
    {OP_HWR, 1'b0, 8'h11, 8'h02, 8'h00},
    {OP_SRD, 1'b0, 8'h00, 8'h00, 8'h00},
    {OP_SWR, 1'b0, 8'h7E, 8'h01, 8'h00},
    {OP_HRD, 1'b1, 8'h00, 8'h01, 8'h01},
    {OP_HRD, 1'b0, 8'h00, 8'h00, 8'h7E},
    {OP_SGF, 1'b0, 8'h04, 8'h04, 8'h00},
    {OP_SGF, 1'b0, 8'hFB, 8'h00, 8'h00},
    {OP_SGF, 1'b0, 8'hFF, 8'h04, 8'h00},
    {OP_HRD, 1'b1, 8'h00, 8'h04, 8'h04},
    {OP_SWR, 1'b0, 8'hA5, 8'h05, 8'h00},
    {OP_HRD, 1'b0, 8'h00, 8'h04, 8'hA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_cs_n = 1'b1, h_addr = 1'b0, h_wr_n = 1'b1, h_rd_n = 1'b1;
  logic [DW-1:0] h_wdata = '0, s_wdata = '0;
  logic s_idr_rd = 1'b0, s_odr_wr = 1'b0, s_gf_wr = 1'b0;
  logic [DW-1:0] h_rdata, s_idr, s_status;
  logic s_irq;
  int checks = 0, fails = 0;
  logic [DW-1:0] rd_got;

  always #10 clk = ~clk;

  hs_mailbox #(.DATA_W(DW), .SYNC_STAGES(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .h_cs_n(h_cs_n), .h_addr(h_addr),
    .h_wr_n(h_wr_n), .h_rd_n(h_rd_n), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .s_idr_rd(s_idr_rd), .s_odr_wr(s_odr_wr), .s_gf_wr(s_gf_wr),
    .s_wdata(s_wdata), .s_idr(s_idr), .s_status(s_status), .s_irq(s_irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic cs_n, input logic a, input logic [DW-1:0] d);
    @(negedge clk); h_cs_n = cs_n; h_addr = a; h_wdata = d; h_wr_n = 1'b0;
    nclk(3); h_wr_n = 1'b1;
    nclk(LAT + 3); h_cs_n = 1'b1;
    nclk(1);
  endtask

  task automatic host_read(input logic cs_n, input logic a, output logic [DW-1:0] d);
    @(negedge clk); h_cs_n = cs_n; h_addr = a; h_rd_n = 1'b0;
    nclk(2); d = h_rdata;
    nclk(1); h_rd_n = 1'b1;
    nclk(LAT + 3); h_cs_n = 1'b1;
    nclk(1);
  endtask

  task automatic slave_pulse(input logic [2:0] op, input logic [DW-1:0] d);
    @(negedge clk); s_wdata = d;
    if (op == OP_SRD) s_idr_rd = 1'b1;
    if (op == OP_SWR) s_odr_wr = 1'b1;
    if (op == OP_SGF) s_gf_wr  = 1'b1;
    nclk(1); s_idr_rd = 1'b0; s_odr_wr = 1'b0; s_gf_wr = 1'b0;
    nclk(2);
  endtask

  initial begin
    nclk(3); rst_n = 1'b1; nclk(4);
    // R1 reset state
    chk("R1 status", s_status, 8'h00);
    chk("R1 idr", s_idr, 8'h00);
    chk("R1 irq", {7'd0, s_irq}, 8'h00);
    h_addr = 1'b0; nclk(1);
    chk("R1 odr", h_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic a; logic [DW-1:0] d, es, er;
      {op, a, d, es, er} = VEC[i];
      case (op)
        OP_HWR: begin
          host_write(1'b0, a, d);
          chk("R2 idr", s_idr, d);
          chk("R3 status", s_status, es);
          chk("R4 irq", {7'd0, s_irq}, {7'd0, es[1]});
        end
        OP_HRD: begin
          host_read(1'b0, a, rd_got);
          chk("R7 rdata", rd_got, er);
          chk("R6 status", s_status, es);
        end
        OP_SWR: begin
          slave_pulse(op, d);
          chk("R5 status", s_status, es);
          h_addr = 1'b0; nclk(1);
          chk("R5 odr", h_rdata, d);
        end
        OP_SGF: begin
          slave_pulse(op, d);
          chk("R9 status", s_status, es);
        end
        default: begin
          slave_pulse(op, d);
          chk("R4 status", s_status, es);
          chk("R4 irq", {7'd0, s_irq}, {7'd0, es[1]});
        end
      endcase
    end

    // R8: deselected write and read have no effect (status is 0x04, odr A5)
    host_write(1'b1, 1'b1, 8'h99);
    chk("R8 idr", s_idr, 8'h11);
    chk("R8 status", s_status, 8'h04);
    slave_pulse(OP_SWR, 8'h3C);
    host_read(1'b1, 1'b0, rd_got);
    chk("R8 obf kept", s_status, 8'h05);
    host_read(1'b0, 1'b0, rd_got);
    chk("R6 clear", s_status, 8'h04);

    // R2 exact latency: flag rises on edge LAT after first high sample
    @(negedge clk); h_cs_n = 1'b0; h_addr = 1'b0; h_wdata = 8'h66; h_wr_n = 1'b0;
    nclk(3); h_wr_n = 1'b1;
    nclk(LAT);
    chk("R2 before", {7'd0, s_status[1]}, 8'h00);
    nclk(1);
    chk("R2 after", {7'd0, s_status[1]}, 8'h01);
    nclk(3); h_cs_n = 1'b1; nclk(1);

    // R4 exact timing: clear on first edge sampling strobe low
    @(negedge clk); s_idr_rd = 1'b1;
    nclk(1); s_idr_rd = 1'b0;
    chk("R4 still set", {7'd0, s_status[1]}, 8'h01);
    nclk(1);
    chk("R4 cleared", {7'd0, s_status[1]}, 8'h00);

    // R10 inbound: host write event and core read fall on one edge
    @(negedge clk); h_cs_n = 1'b0; h_addr = 1'b1; h_wdata = 8'h42; h_wr_n = 1'b0;
    s_idr_rd = 1'b1;
    nclk(3); h_wr_n = 1'b1;
    nclk(LAT); s_idr_rd = 1'b0;
    nclk(1);
    chk("R10 ibf set wins", {7'd0, s_status[1]}, 8'h01);
    nclk(3); h_cs_n = 1'b1; nclk(1);

    // R10 outbound: host data read clear and core write fall on one edge
    @(negedge clk); h_cs_n = 1'b0; h_addr = 1'b0; h_rd_n = 1'b0;
    s_odr_wr = 1'b1; s_wdata = 8'h81;
    nclk(3); h_rd_n = 1'b1;
    nclk(LAT); s_odr_wr = 1'b0;
    nclk(1);
    chk("R10 obf set wins", {7'd0, s_status[0]}, 8'h01);
    nclk(3); h_cs_n = 1'b1; nclk(1);

    // R1 reset again
    rst_n = 1'b0; nclk(2);
    chk("R1 status after reset", s_status, 8'h00);
    rst_n = 1'b1; nclk(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule